// File: doc/BRIEF.md
# Polled Keyboard Character Port

This block is a slave on a CPU system bus that hands keyboard characters to software. A keyboard-side source offers an 8-bit character with a one-cycle valid strobe. The port keeps the most recent character and raises a ready flag. The CPU reads two byte-wide registers. The status byte holds the ready flag and a sticky overrun flag. The data byte holds the character. Reading the data byte clears the ready flag in hardware, so software never writes an acknowledge.

Software polls as follows. It reads the status byte and masks bit 7 until the bit is set, then reads the data byte. The flags are held by a four-state machine:

- `ST_EMPTY`: no character and no loss.
- `ST_READY`: a character is waiting.
- `ST_READY_LOST`: a character is waiting and an earlier one was overwritten.
- `ST_EMPTY_LOST`: no character is waiting, but a loss has not yet been reported.

The transitions are:

- `ST_EMPTY` goes to `ST_READY` on a strobe.
- `ST_READY` goes to `ST_EMPTY` on a data read without a strobe. It goes to `ST_READY_LOST` on a strobe without a data read.
- `ST_READY_LOST` goes to `ST_EMPTY_LOST` on a data read without a strobe. It goes to `ST_READY` on a status read without a strobe.
- `ST_EMPTY_LOST` goes to `ST_EMPTY` on a status read without a strobe. On a strobe it goes to `ST_READY_LOST`, or to `ST_READY` if a status read happens in the same cycle.

Every other combination keeps the current state.

Top module: `kbd_port_ctrl`

## Requirements
- R1: After reset, the status byte reads 0x00 and the data byte reads 0x00.
- R2: A strobe sets the ready flag, which is bit 7 of the status byte at address 0x0A00. The flag is visible from the next cycle.
- R3: A read of address 0x0A01 returns the stored character in the same cycle the read is asserted.
- R4: A data read without a strobe clears the ready flag from the next cycle.
- R5: A strobe while ready is set, with no data read in that cycle, replaces the character and sets the overrun flag (bit 6 of the status byte).
- R6: A status read clears the overrun flag from the next cycle. If a strobe in that same cycle causes a new overrun, the flag stays set.
- R7: When a strobe and a data read fall in the same cycle, the read returns the old character. The new character is stored, ready stays set and no overrun is recorded.
- R8: A read of any other address drives `bus_sel` low and `bus_rdata` to 0x00.
- R9: Writes to either register change neither the character nor the flags.
- R10: Bits 5:0 of the status byte always read as zero.
- R11: The overrun flag survives a data read and is cleared only by a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address from the CPU |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wr | input | 1 | Write strobe (ignored by the registers) |
| bus_wdata | input | 8 | Write data (ignored) |
| bus_rdata | output | 8 | Read data; 0x00 when not selected |
| bus_sel | output | 1 | High when this block drives the read data |
| key_char | input | 8 | Character from the keyboard side |
| key_valid | input | 1 | One-cycle strobe qualifying `key_char` |

## Verification
The bench builds the port with its default parameters: a 16-bit address and registers at 0x0A00 and 0x0A01. With neighbouring addresses 0x0A02 and 0x0B00 it checks that partial decodes stay unselected. The default widths let every state of the flag machine be reached by short strobe and read sequences. These include the same-cycle collisions of a strobe with a data read and of a strobe with a status read.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY      = 2'd0,
        ST_READY      = 2'd1,
        ST_READY_LOST = 2'd2,
        ST_EMPTY_LOST = 2'd3
    } flag_state_t;

    localparam int RDY_BIT = 7;
    localparam int OVR_BIT = 6;

endpackage

// File: rtl/kbd_addr_dec.sv
module kbd_addr_dec #(
    parameter int               ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h0A00,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h0A01
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    output logic              stat_rd,
    output logic              data_rd,
    output logic              sel
);

    always_comb begin
        stat_rd = rd && (addr == STAT_ADDR);
        data_rd = rd && (addr == DATA_ADDR);
        sel     = stat_rd || data_rd;
    end

endmodule

// File: rtl/kbd_flag_fsm.sv
module kbd_flag_fsm
    import kbd_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_stb,
    input  logic data_rd,
    input  logic stat_rd,
    output logic ready,
    output logic lost
);

    flag_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (key_stb) state_d = ST_READY;
            end
            ST_READY: begin
                if (key_stb)      state_d = data_rd ? ST_READY : ST_READY_LOST;
                else if (data_rd) state_d = ST_EMPTY;
            end
            ST_READY_LOST: begin
                if (key_stb)      state_d = ST_READY_LOST;
                else if (data_rd) state_d = ST_EMPTY_LOST;
                else if (stat_rd) state_d = ST_READY;
            end
            ST_EMPTY_LOST: begin
                if (key_stb)      state_d = stat_rd ? ST_READY : ST_READY_LOST;
                else if (stat_rd) state_d = ST_EMPTY;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        ready = 1'b0;
        lost  = 1'b0;
        unique case (state_q)
            ST_EMPTY:      begin ready = 1'b0; lost = 1'b0; end
            ST_READY:      begin ready = 1'b1; lost = 1'b0; end
            ST_READY_LOST: begin ready = 1'b1; lost = 1'b1; end
            ST_EMPTY_LOST: begin ready = 1'b0; lost = 1'b1; end
            default:       begin ready = 1'b0; lost = 1'b0; end
        endcase
    end

endmodule

// File: rtl/kbd_char_reg.sv
module kbd_char_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end

endmodule

// File: rtl/kbd_port_ctrl.sv
module kbd_port_ctrl
    import kbd_port_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h0A00,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h0A01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_sel,
    input  logic [7:0]        key_char,
    input  logic              key_valid
);

    localparam int BYTE_W = 8;

    logic              stat_rd, data_rd;
    logic              ready, lost;
    logic [BYTE_W-1:0] char_q;
    logic [BYTE_W-1:0] status_byte;
    logic              unused_wr;

    assign unused_wr = bus_wr ^ (^bus_wdata);

    kbd_addr_dec #(
        .ADDR_W   (ADDR_W),
        .STAT_ADDR(STAT_ADDR),
        .DATA_ADDR(DATA_ADDR)
    ) u_dec (
        .addr   (bus_addr),
        .rd     (bus_rd),
        .stat_rd(stat_rd),
        .data_rd(data_rd),
        .sel    (bus_sel)
    );

    kbd_flag_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_stb(key_valid),
        .data_rd(data_rd),
        .stat_rd(stat_rd),
        .ready  (ready),
        .lost   (lost)
    );

    kbd_char_reg #(.W(BYTE_W)) u_char (
        .clk  (clk),
        .rst_n(rst_n),
        .load (key_valid),
        .din  (key_char),
        .dout (char_q)
    );

    always_comb begin
        status_byte          = '0;
        status_byte[RDY_BIT] = ready;
        status_byte[OVR_BIT] = lost;
    end

    always_comb begin
        if (stat_rd)      bus_rdata = status_byte;
        else if (data_rd) bus_rdata = char_q;
        else              bus_rdata = '0;
    end

endmodule

// File: rtl/kbd_port_chk.sv
module kbd_port_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h0A00,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h0A01
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_rdata,
    input logic              bus_sel,
    input logic [7:0]        key_char,
    input logic              key_valid,
    input logic              ready,
    input logic              lost,
    input logic [7:0]        char_q
);

    // R2
    strobe_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> ready);

    // R4
    data_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == DATA_ADDR && !key_valid) |=> !ready);

    // R5
    overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && ready && !(bus_rd && bus_addr == DATA_ADDR)) |=> lost);

    // R8
    unselected_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (bus_rdata == 8'h00));

    // R8
    sel_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |-> bus_rd);

    // R9
    write_keeps_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !key_valid) |=> $stable(char_q));

    // R10
    status_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == STAT_ADDR) |-> (bus_rdata[5:0] == 6'd0));

    // R11
    overrun_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && !(bus_rd && bus_addr == STAT_ADDR)) |=> lost);

endmodule

bind kbd_port_ctrl kbd_port_chk #(
    .ADDR_W   (ADDR_W),
    .STAT_ADDR(STAT_ADDR),
    .DATA_ADDR(DATA_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_rdata(bus_rdata),
    .bus_sel  (bus_sel),
    .key_char (key_char),
    .key_valid(key_valid),
    .ready    (ready),
    .lost     (lost),
    .char_q   (char_q)
);

// File: tb/kbd_port_ctrl_test.sv
module kbd_port_ctrl_test;

    localparam logic [15:0] A_STAT = 16'h0A00;
    localparam logic [15:0] A_DATA = 16'h0A01;

    typedef struct {
        logic       sel;
        logic [7:0] data;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_sel;
    logic [7:0]  key_char = '0;
    logic        key_valid = 1'b0;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    logic       m_rdy = 1'b0;
    logic       m_ovr = 1'b0;
    logic [7:0] m_chr = 8'h00;

    always #2.5 clk = ~clk;

    kbd_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_sel(bus_sel), .key_char(key_char), .key_valid(key_valid)
    );

    always @(negedge clk) begin
        if (bus_rd) begin
            exp_t e;
            n_chk++;
            if (q.size() == 0) begin
                n_fail++;
                $display("FAIL %s: unexpected read, actual sel=%0b data=%02h expected none",
                         "R3", bus_sel, bus_rdata);
            end else begin
                e = q.pop_front();
                if (bus_sel !== e.sel || bus_rdata !== e.data) begin
                    n_fail++;
                    $display("FAIL %s: actual sel=%0b data=%02h expected sel=%0b data=%02h",
                             e.tag, bus_sel, bus_rdata, e.sel, e.data);
                end
            end
        end
    end

    task automatic cyc(input logic kv, input logic [7:0] ch, input logic rd,
                       input logic wr, input logic [15:0] a, input string tag);
        logic       n_rdy, n_ovr;
        logic       drd, srd;
        exp_t       e;
        @(posedge clk); #1;
        key_valid = kv; key_char = ch; bus_rd = rd; bus_wr = wr;
        bus_addr = a; bus_wdata = 8'hFF;
        drd = rd && a == A_DATA;
        srd = rd && a == A_STAT;
        if (rd) begin
            e.tag = tag;
            if (srd)      begin e.sel = 1'b1; e.data = {m_rdy, m_ovr, 6'd0}; end
            else if (drd) begin e.sel = 1'b1; e.data = m_chr; end
            else          begin e.sel = 1'b0; e.data = 8'h00; end
            q.push_back(e);
        end
        n_rdy = kv ? 1'b1 : (drd ? 1'b0 : m_rdy);
        if (kv && m_rdy && !drd) n_ovr = 1'b1;
        else if (srd)            n_ovr = 1'b0;
        else                     n_ovr = m_ovr;
        if (kv) m_chr = ch;
        m_rdy = n_rdy;
        m_ovr = n_ovr;
    endtask

    task automatic idle();
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 16'h0000, "");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        cyc(0, 8'h00, 1, 0, A_STAT, "R1 status");
        cyc(0, 8'h00, 1, 0, A_DATA, "R1 data");
        // R2 ready after strobe, R3 data, R4 cleared, R10
        cyc(1, 8'h41, 0, 0, 16'h0, "");
        cyc(0, 8'h00, 1, 0, A_STAT, "R2 ready R10");
        cyc(0, 8'h00, 1, 0, A_DATA, "R3 data");
        cyc(0, 8'h00, 1, 0, A_STAT, "R4 cleared");
        // R8 unmapped
        cyc(0, 8'h00, 1, 0, 16'h0A02, "R8 0A02");
        cyc(0, 8'h00, 1, 0, 16'h0B00, "R8 0B00");
        // R5 overrun, R6 status read clears it
        cyc(1, 8'h12, 0, 0, 16'h0, "");
        cyc(1, 8'h34, 0, 0, 16'h0, "");
        cyc(0, 8'h00, 1, 0, A_STAT, "R5 overrun");
        cyc(0, 8'h00, 1, 0, A_STAT, "R6 cleared");
        cyc(0, 8'h00, 1, 0, A_DATA, "R5 replaced char");
        // R7 collision of strobe and data read
        cyc(1, 8'h55, 0, 0, 16'h0, "");
        cyc(1, 8'h66, 1, 0, A_DATA, "R7 old char");
        cyc(0, 8'h00, 1, 0, A_STAT, "R7 ready no overrun");
        cyc(0, 8'h00, 1, 0, A_DATA, "R7 new char");
        // R9 writes ignored
        cyc(0, 8'h00, 0, 1, A_DATA, "");
        cyc(0, 8'h00, 0, 1, A_STAT, "");
        cyc(0, 8'h00, 1, 0, A_STAT, "R9 status");
        cyc(0, 8'h00, 1, 0, A_DATA, "R9 data");
        // R11 overrun survives data read
        cyc(1, 8'h01, 0, 0, 16'h0, "");
        cyc(1, 8'h02, 0, 0, 16'h0, "");
        cyc(0, 8'h00, 1, 0, A_DATA, "R11 data");
        cyc(0, 8'h00, 1, 0, A_STAT, "R11 lost kept");
        cyc(0, 8'h00, 1, 0, A_STAT, "R6 lost cleared");
        // R6 strobe during status read while ready: overrun set wins
        cyc(1, 8'h0A, 0, 0, 16'h0, "");
        cyc(1, 8'h0B, 1, 0, A_STAT, "R6 pre");
        cyc(0, 8'h00, 1, 0, A_STAT, "R6 set wins");
        cyc(0, 8'h00, 1, 0, A_DATA, "R6 char");
        idle();
        idle();
        n_chk++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R3: actual %0d pending reads expected 0", q.size());
        end
        finish_run();
    end

endmodule